// File: doc/BRIEF.md
# Inter-Thread Counting Semaphore Cell

This block is one storage cell for synchronising hardware threads. It holds a 16-bit count and acts as a counting semaphore. A requester issues one access per cycle. Each access carries a thread number, a view code, a direction flag and write data. The view picks how the access treats the cell:

- **Blocking P/V view.** A read takes a unit from the count. A write returns a unit to it.
- **Non-blocking P/V view.** The same read and write, but a read never stalls the thread.
- **Raw view.** Reads or overwrites the count directly.
- **Control view.** Reads or writes a small tag word.

A read in the blocking P/V view can find the count empty. The cell then reports the access as blocked and records the thread in a wait bitmap. The next V write clears that bitmap, and the waiting threads then retry. The tag has a read-only kind bit. It reads 0 on this cell, which marks it as a semaphore and not a queue. The tag also holds empty and full flags, which P/V traffic never changes.

Every response is registered. It appears one clock after the request, together with the updated wait bitmap.

Top module: `sem_cell`

## Requirements
- R1: After a synchronous active-high reset, the following hold: the count equals parameter INIT_COUNT (default 0), the wait bitmap is all zero, the tag is all zero, and `rsp_valid` and `rsp_blocked` are 0.
- R2: An access presented in cycle N produces `rsp_valid`=1 in cycle N+1. With no request, `rsp_valid` is 0. `rsp_blocked` is never 1 without `rsp_valid`. View codes are: 0 control, 1 raw, 2 blocking P/V, 3 non-blocking P/V.
- R3: A read in view 2 or 3 with a nonzero count returns the count and then lowers it by exactly 1.
- R4: A write in view 2 or 3 raises the count by exactly 1, whatever the write data. At 0xFFFF the count stays at 0xFFFF. A write response returns data 0.
- R5: A read in view 2 with a count of 0 returns data 0 with `rsp_blocked`=1. It leaves the count at 0 and sets bit `req_thread` of `waiters`.
- R6: A read in view 3 with a count of 0 returns 0 with `rsp_blocked`=0. It changes neither the count nor `waiters`.
- R7: A write in view 2 or 3 clears all of `waiters`. A successful read in view 2 or 3 clears only the issuing thread's bit.
- R8: A raw-view read returns the count unchanged. A raw-view write loads the count with the low 16 bits of `req_wdata`. Raw accesses never block and never change `waiters`.
- R9: A control read returns the tag zero-extended. The tag layout is: bit 0 empty flag, bit 1 full flag, bit 2 kind (always 0), bits 7:3 a writable field. A control write updates bits 7:3, 1 and 0, and bit 2 stays 0. Control accesses never block.
- R10: P/V accesses in views 2 and 3 leave the tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access present this cycle |
| req_thread | input | TID_W | Issuing thread number |
| req_view | input | 2 | View code (0 control, 1 raw, 2 blocking P/V, 3 non-blocking P/V) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | CNT_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | CNT_W | Read data |
| rsp_blocked | output | 1 | Access stalled; thread must retry |
| waiters | output | NTHREADS | Bitmap of threads blocked on the cell |

## Verification
On every cycle, the assertions check the following:

- Each P read lowers the count by one, and each V write raises it by one or holds it at saturation.
- A blocked response comes only with a valid response and leaves the count at zero.
- A V write empties the wait bitmap.
- The kind bit of a control read is zero.

Some properties depend on a chosen order of accesses, so only the bench scenarios can show them. These are:

- Which data each view returns.
- That raw and non-blocking accesses leave the bitmap alone.
- That a successful retry clears only its own thread bit.
- That P/V traffic leaves the tag flags untouched.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    VIEW_CTL  = 2'd0,
    VIEW_RAW  = 2'd1,
    VIEW_SYNC = 2'd2,
    VIEW_TRY  = 2'd3
  } view_t;

  localparam int TAG_W    = 8;
  localparam int TAG_KIND = 2;
endpackage

// File: rtl/sem_counter.sv
module sem_counter #(
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic             push,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                       count <= CNT_W'(INIT_COUNT);
    else if (load)                 count <= load_val;
    else if (pop && count != '0)   count <= count - 1'b1;
    else if (push && count != CMAX) count <= count + 1'b1;
  end

  // R3: a P read takes exactly one unit
  a_r3_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (pop && !load && count != '0) |=> count == $past(count) - 1'b1);
  // R4: a V write adds exactly one unit below saturation
  a_r4_push_inc: assert property (@(posedge clk) disable iff (rst)
    (push && !load && count != CMAX) |=> count == $past(count) + 1'b1);
  // R4: saturation holds at the maximum
  a_r4_push_sat: assert property (@(posedge clk) disable iff (rst)
    (push && !load && count == CMAX) |=> count == CMAX);
endmodule

// File: rtl/sem_waitmap.sv
module sem_waitmap #(
  parameter int NTHREADS = 4,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic                clr_one,
  input  logic [TID_W-1:0]    tid,
  input  logic                clr_all,
  output logic [NTHREADS-1:0] map
);
  for (genvar t = 0; t < NTHREADS; t++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all)                          map[t] <= 1'b0;
      else if (set_en && tid == TID_W'(t))         map[t] <= 1'b1;
      else if (clr_one && tid == TID_W'(t))        map[t] <= 1'b0;
    end
  end

  // R7: a V write empties the bitmap
  a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> map == '0);
endmodule

// File: rtl/sem_tag.sv
module sem_tag
  import sem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (rst)        tag <= '0;
    else if (wr_en) tag <= wdata & ~(TAG_W'(1) << TAG_KIND);
  end

  // R10: the tag moves only on a control write
  a_r10_tag_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(tag));
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
#(
  parameter int NTHREADS   = 4,
  parameter int CNT_W      = 16,
  parameter int INIT_COUNT = 0,
  localparam int TID_W = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [TID_W-1:0]    req_thread,
  input  logic [1:0]          req_view,
  input  logic                req_write,
  input  logic [CNT_W-1:0]    req_wdata,
  output logic                rsp_valid,
  output logic [CNT_W-1:0]    rsp_rdata,
  output logic                rsp_blocked,
  output logic [NTHREADS-1:0] waiters
);
  view_t            view;
  logic             is_pv, rd, cnt_zero;
  logic             pop, push, blk_now, raw_wr, tag_wr;
  logic [CNT_W-1:0] count, rdata_next;
  logic [TAG_W-1:0] tag;
  logic             last_ctl_rd;

  assign view     = view_t'(req_view);
  assign is_pv    = (view == VIEW_SYNC) || (view == VIEW_TRY);
  assign rd       = !req_write;
  assign cnt_zero = (count == '0);
  assign pop      = req_valid && is_pv && rd && !cnt_zero;
  assign push     = req_valid && is_pv && req_write;
  assign blk_now  = req_valid && (view == VIEW_SYNC) && rd && cnt_zero;
  assign raw_wr   = req_valid && (view == VIEW_RAW) && req_write;
  assign tag_wr   = req_valid && (view == VIEW_CTL) && req_write;

  always_comb begin
    rdata_next = '0;
    if (rd) begin
      unique case (view)
        VIEW_CTL:  rdata_next = CNT_W'(tag);
        VIEW_RAW:  rdata_next = count;
        default:   rdata_next = cnt_zero ? '0 : count;
      endcase
    end
  end

  sem_counter #(.CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) i_cnt (
    .clk(clk), .rst(rst), .pop(pop), .push(push),
    .load(raw_wr), .load_val(req_wdata), .count(count));

  sem_waitmap #(.NTHREADS(NTHREADS)) i_wait (
    .clk(clk), .rst(rst), .set_en(blk_now), .clr_one(pop),
    .tid(req_thread), .clr_all(push), .map(waiters));

  sem_tag i_tag (
    .clk(clk), .rst(rst), .wr_en(tag_wr),
    .wdata(req_wdata[TAG_W-1:0]), .tag(tag));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_blocked <= 1'b0;
      last_ctl_rd <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= req_valid ? rdata_next : '0;
      rsp_blocked <= blk_now;
      last_ctl_rd <= req_valid && (view == VIEW_CTL) && rd;
    end
  end

  // R2: blocked only accompanies a response
  a_r2_blk_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_blocked |-> rsp_valid);
  // R5: a blocked read leaves the count empty
  a_r5_blk_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_blocked |-> count == '0);
  // R9: the kind bit reads zero on a control read
  a_r9_kind_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && last_ctl_rd) |-> rsp_rdata[TAG_KIND] == 1'b0);
endmodule

// File: tb/test_sem_cell.sv
module test_sem_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {view[1:0], write, tid[1:0], wdata[15:0], exp_rdata[15:0], exp_blk, exp_map[3:0]}
  localparam logic [41:0] VEC [NV] = '{
    {2'd3, 1'b0, 2'd1, 16'h0000, 16'h0000, 1'b0, 4'b0000}, // R6
    {2'd2, 1'b0, 2'd2, 16'h0000, 16'h0000, 1'b1, 4'b0100}, // R5
    {2'd2, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 4'b0101}, // R5
    {2'd2, 1'b1, 2'd3, 16'hABCD, 16'h0000, 1'b0, 4'b0000}, // R4 R7
    {2'd3, 1'b1, 2'd3, 16'h1234, 16'h0000, 1'b0, 4'b0000}, // R4
    {2'd1, 1'b0, 2'd0, 16'h0000, 16'h0002, 1'b0, 4'b0000}, // R8
    {2'd2, 1'b0, 2'd1, 16'h0000, 16'h0002, 1'b0, 4'b0000}, // R3
    {2'd3, 1'b0, 2'd1, 16'h0000, 16'h0001, 1'b0, 4'b0000}, // R3
    {2'd3, 1'b0, 2'd1, 16'h0000, 16'h0000, 1'b0, 4'b0000}, // R6
    {2'd2, 1'b0, 2'd3, 16'h0000, 16'h0000, 1'b1, 4'b1000}, // R5
    {2'd1, 1'b1, 2'd0, 16'h0005, 16'h0000, 1'b0, 4'b1000}, // R8
    {2'd1, 1'b0, 2'd0, 16'h0000, 16'h0005, 1'b0, 4'b1000}, // R8
    {2'd2, 1'b0, 2'd3, 16'h0000, 16'h0005, 1'b0, 4'b0000}  // R7 R3
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_thread = '0;
  logic [1:0]  req_view = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_blocked;
  logic [15:0] rsp_rdata;
  logic [3:0]  waiters;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_cell i_sem_cell (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_thread(req_thread),
    .req_view(req_view), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_blocked(rsp_blocked), .waiters(waiters));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive at a falling edge, response is sampled at the next falling edge
  task automatic access(logic [1:0] v, logic w, logic [1:0] t, logic [15:0] d);
    req_valid = 1'b1; req_view = v; req_write = w; req_thread = t; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 blocked", 32'(rsp_blocked), 0);
    check("R1 waiters", 32'(waiters), 0);
    rst = 1'b0;
    access(2'd1, 1'b0, 2'd0, 16'h0);
    check("R1 count", 32'(rsp_rdata), 0);
    access(2'd0, 1'b0, 2'd0, 16'h0);
    check("R1 tag", 32'(rsp_rdata), 0);
    @(negedge clk);
    check("R2 idle no rsp", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][41:40], VEC[i][39], VEC[i][38:37], VEC[i][36:21]);
      check("R2 rsp_valid", 32'(rsp_valid), 1);
      check("R3-vector rdata", 32'(rsp_rdata), 32'(VEC[i][20:5]));
      check("R5 vector blocked", 32'(rsp_blocked), 32'(VEC[i][4]));
      check("R7 vector waiters", 32'(waiters), 32'(VEC[i][3:0]));
    end

    // R4 saturation
    access(2'd1, 1'b1, 2'd0, 16'hFFFE);
    access(2'd2, 1'b1, 2'd0, 16'h0);
    access(2'd3, 1'b1, 2'd0, 16'h0);
    access(2'd1, 1'b0, 2'd0, 16'h0);
    check("R4 saturate", 32'(rsp_rdata), 32'hFFFF);

    // R9 control write, kind bit forced to zero
    access(2'd0, 1'b1, 2'd1, 16'h00FF);
    check("R9 ctl write no block", 32'(rsp_blocked), 0);
    access(2'd0, 1'b0, 2'd1, 16'h0);
    check("R9 tag read", 32'(rsp_rdata), 32'h00FB);

    // R10 P/V traffic keeps tag
    access(2'd1, 1'b1, 2'd0, 16'h0000);
    access(2'd2, 1'b0, 2'd2, 16'h0);
    check("R5 block again", 32'(rsp_blocked), 1);
    access(2'd2, 1'b1, 2'd2, 16'h0);
    access(2'd3, 1'b0, 2'd2, 16'h0);
    check("R3 try read one", 32'(rsp_rdata), 1);
    access(2'd0, 1'b0, 2'd0, 16'h0);
    check("R10 tag unchanged", 32'(rsp_rdata), 32'h00FB);
    access(2'd1, 1'b0, 2'd0, 16'h0);
    check("R5 count stays zero", 32'(rsp_rdata), 0);

    // R1 reset again clears bitmap
    access(2'd2, 1'b0, 2'd1, 16'h0);
    check("R5 bit1 set", 32'(waiters), 32'h2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 waiters after reset", 32'(waiters), 0);
    check("R1 rsp after reset", 32'(rsp_valid), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule